// File: doc/BRIEF.md
# Frame-Synchronized Serial Time-Slot Port

This block connects a set of serial downstream data lines and serial upstream data lines to a parallel byte interface. Timing comes from an external data clock and a frame sync line. The block runs entirely on a fast system clock. It synchronizes the data clock, the frame sync and the downstream lines through flip-flop chains, and it finds the data clock edges by comparing the synchronized values from one system cycle to the next. A frame holds `SLOTS` time slots of eight bits each. Every slot is carried on all lanes at the same time, and each byte is sent most significant bit first.

A 3-bit mode input selects the bit rate. In the double-rate mode (code 0) each bit takes two data clock periods. In every other mode each bit takes one period. Each received byte is delivered with a one-cycle valid strobe and the index of its slot. Upstream bytes are requested one slot before they are needed: a request strobe carries the slot index, and the byte on the transmit input is captured in that same cycle. When a frame sync arrives early, the frame restarts at once. When it arrives late, the block waits idle with its upstream lines high until the sync comes.

Top module: `tsi_serial_port`

## Requirements
- R1: After reset, every upstream line is 1, and `rx_valid` and `tx_req` are both 0.
- R2: With mode code 0, no downstream bit is sampled on the falling edge where the frame start is seen. The first bit is sampled on the next falling edge, and the following bits on every second falling edge after that.
- R3: With any nonzero mode code, the first downstream bit is sampled on the same falling edge where the frame start is seen, and each later bit on each following falling edge.
- R4: A frame starts on a data clock falling edge where the frame sync is high, provided it was low at the previous falling edge. Holding frame sync high over several falling edges does not start the frame again.
- R5: Each completed received byte produces a single-cycle `rx_valid` pulse. `rx_slot` gives the slot index, counting from 0 at frame start, and lane i's byte appears on `rx_byte[8i+7:8i]`. The first bit received in a slot lands in bit 7.
- R6: Upstream bits leave MSB first and change on data clock rising edges. With mode code 0, bit k of the frame is driven on the rising edge just before the falling edge that samples downstream bit k. In the other modes it is driven on the rising edge just after that falling edge.
- R7: When transmission of slot s begins, `tx_req` pulses for one cycle with `tx_slot` = (s+1) mod SLOTS. The `tx_byte` value present in that cycle is sent in that next slot; for the last slot, this is slot 0 of the following frame. Until a slot-0 byte has been requested after reset, slot 0 sends 8'hFF.
- R8: A frame start that arrives before the current frame has finished clears the bit and slot counters. Reception restarts at slot 0, and upstream data from slot 1 onward follows R6 and R7. Only slot 0 of that frame may carry stale upstream data.
- R9: Once the last bit of a frame has been handled and no new frame start has come, no `rx_valid` or `tx_req` pulses occur. The upstream lines return to 1 on the next rising edge and stay there until a frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the data clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Rate select: 0 double-rate, any other value single-rate |
| dclk | input | 1 | External data clock |
| fsync | input | 1 | External frame sync, active high |
| dn | input | LANES | Serial downstream data lines |
| up | output | LANES | Serial upstream data lines |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_slot | output | clog2(SLOTS) | Slot index of the received byte |
| rx_byte | output | 8*LANES | Received bytes, one per lane |
| tx_req | output | 1 | One-cycle request for the next slot's upstream bytes |
| tx_slot | output | clog2(SLOTS) | Slot index being requested |
| tx_byte | input | 8*LANES | Upstream bytes, captured while tx_req is high |

## Verification
Some rules are checked on every cycle by the assertions. These include how the counters are armed at a frame start in each rate mode, that two sampling edges are never adjacent in double-rate mode, that receive strobes come only after a sampling event, that requests stay inside a running frame, and that the upstream lines sit high whenever transmission is stopped. Other behaviour can only be shown by the bench's scenarios, because it concerns whole frames on the serial lines. This covers the bit positions of sampling and driving relative to the frame sync, MSB-first byte assembly and the slot numbering, the one-slot-ahead capture that includes the wrap to slot 0 and the 8'hFF after reset, the restart on an early sync, and the idle gap and resumption on a late sync.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  localparam int BYTE_W = 8;

  // Slot counter step with wrap at the frame length.
  function automatic int unsigned slot_after(input int unsigned s, input int unsigned n);
    return (s + 1 >= n) ? 0 : s + 1;
  endfunction

  // Mode code 0 selects the double-rate data clock; every other code is single-rate.
  function automatic logic is_double(input logic [2:0] m);
    return m == 3'd0;
  endfunction

endpackage

// File: rtl/tsi_sync.sv
module tsi_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '0;
    else        st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[i] <= '0;
      else        st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/tsi_timing.sv
module tsi_timing
  import tsi_pkg::*;
#(
  parameter int SLOTS = 32,
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dclk_s,
  input  logic          fs_s,
  input  logic          dbl,
  output logic          smp,
  output logic          byte_done,
  output logic          drv,
  output logic          load,
  output logic          go_idle,
  output logic          tx_run,
  output logic          rx_valid,
  output logic [SW-1:0] rx_slot,
  output logic          tx_req,
  output logic [SW-1:0] tx_slot
);

  localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

  // Edge events of the synchronized data clock.
  logic dclk_q, fs_q, rise, fall, start;
  assign rise  = dclk_s & ~dclk_q;
  assign fall  = ~dclk_s & dclk_q;
  assign start = fall & fs_s & ~fs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_q <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      dclk_q <= dclk_s;
      if (fall) fs_q <= fs_s;
    end
  end

  // Receive position: bit in slot, slot in frame, half-step phase for double rate.
  logic          rx_act, ph, frame_end;
  logic [2:0]    rbit, cur_bit;
  logic [SW-1:0] rslot, cur_slot;

  assign cur_bit   = start ? 3'd0 : rbit;
  assign cur_slot  = start ? '0 : rslot;
  assign smp       = fall & (start ? ~dbl : (rx_act & (~dbl | ph)));
  assign byte_done = smp & (cur_bit == 3'd7);
  assign frame_end = byte_done & (cur_slot == LAST_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_act <= 1'b0;
      ph     <= 1'b0;
      rbit   <= 3'd0;
      rslot  <= '0;
    end else if (fall && (start || rx_act)) begin
      if (smp) begin
        rbit   <= cur_bit + 3'd1;
        rslot  <= (cur_bit == 3'd7) ? SW'(slot_after(32'(cur_slot), SLOTS)) : cur_slot;
        ph     <= 1'b0;
        rx_act <= ~frame_end;
      end else begin
        ph     <= 1'b1;
        rx_act <= 1'b1;
        rbit   <= cur_bit;
        rslot  <= cur_slot;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_slot  <= '0;
    end else begin
      rx_valid <= byte_done;
      if (byte_done) rx_slot <= cur_slot;
    end
  end

  // Transmit position, advanced on eligible rising edges.
  logic          tdone;
  logic [2:0]    tbit;
  logic [SW-1:0] tslot;

  assign drv     = rise & tx_run & ~tdone & (~dbl | ph);
  assign load    = drv & (tbit == 3'd0);
  assign go_idle = rise & tx_run & tdone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_run <= 1'b0;
      tdone  <= 1'b0;
      tbit   <= 3'd0;
      tslot  <= '0;
    end else if (start) begin
      tx_run <= 1'b1;
      tdone  <= 1'b0;
      tbit   <= 3'd0;
      tslot  <= '0;
    end else if (go_idle) begin
      tx_run <= 1'b0;
    end else if (drv) begin
      tbit <= tbit + 3'd1;
      if (tbit == 3'd7) begin
        tslot <= SW'(slot_after(32'(tslot), SLOTS));
        if (tslot == LAST_SLOT) tdone <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_req  <= 1'b0;
      tx_slot <= '0;
    end else begin
      tx_req <= load;
      if (load) tx_slot <= SW'(slot_after(32'(tslot), SLOTS));
    end
  end

  // Checker state: was the previous falling edge a sampling edge.
  logic prev_smp;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prev_smp <= 1'b0;
    else if (fall) prev_smp <= smp;
  end

  AST_DBL_START_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dbl) |=> (rx_act && ph && rbit == 3'd0 && rslot == '0)); // R2
  AST_DBL_SAMPLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && dbl && prev_smp && !start) |-> !smp); // R2
  AST_SINGLE_START_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !dbl) |=> (rbit == 3'd1 && rslot == '0)); // R3
  AST_RXV_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(smp)); // R5
  AST_TXREQ_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> tx_run); // R7
  AST_START_RESETS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (tx_run && !tdone && tbit == 3'd0 && tslot == '0)); // R8

endmodule

// File: rtl/tsi_lane.sv
module tsi_lane
  import tsi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dn_s,
  input  logic              smp,
  input  logic              byte_done,
  input  logic              drv,
  input  logic              load,
  input  logic              go_idle,
  input  logic              run,
  input  logic              tx_req,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              up,
  output logic [BYTE_W-1:0] rx_byte
);

  logic [BYTE_W-1:0] rx_sh, hold, tx_sh;

  // Receive: shift MSB first, publish on the eighth bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh   <= '0;
      rx_byte <= '0;
    end else if (smp) begin
      rx_sh <= {rx_sh[BYTE_W-2:0], dn_s};
      if (byte_done) rx_byte <= {rx_sh[BYTE_W-2:0], dn_s};
    end
  end

  // Transmit: hold register filled one slot ahead, shifted MSB first.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold  <= '1;
      tx_sh <= '1;
      up    <= 1'b1;
    end else begin
      if (tx_req) hold <= tx_byte;
      if (go_idle) begin
        up <= 1'b1;
      end else if (load) begin
        up    <= hold[BYTE_W-1];
        tx_sh <= {hold[BYTE_W-2:0], 1'b1};
      end else if (drv) begin
        up    <= tx_sh[BYTE_W-1];
        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};
      end
    end
  end

  AST_UP_HIGH_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> up); // R9

endmodule

// File: rtl/tsi_serial_port.sv
module tsi_serial_port
  import tsi_pkg::*;
#(
  parameter int SLOTS       = 32,
  parameter int LANES       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int SW         = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          mode,
  input  logic                dclk,
  input  logic                fsync,
  input  logic [LANES-1:0]    dn,
  output logic [LANES-1:0]    up,
  output logic                rx_valid,
  output logic [SW-1:0]       rx_slot,
  output logic [8*LANES-1:0]  rx_byte,
  output logic                tx_req,
  output logic [SW-1:0]       tx_slot,
  input  logic [8*LANES-1:0]  tx_byte
);

  localparam int SYNC_W = LANES + 2;

  logic [SYNC_W-1:0] sync_q;
  logic [LANES-1:0]  dn_s;
  logic              dclk_s, fs_s, dbl;

  tsi_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({fsync, dclk, dn}), .q(sync_q)
  );

  assign {fs_s, dclk_s, dn_s} = sync_q;
  assign dbl = is_double(mode);

  logic smp, byte_done, drv, load, go_idle, tx_run;

  tsi_timing #(.SLOTS(SLOTS)) u_timing (
    .clk(clk), .rst_n(rst_n), .dclk_s(dclk_s), .fs_s(fs_s), .dbl(dbl),
    .smp(smp), .byte_done(byte_done), .drv(drv), .load(load),
    .go_idle(go_idle), .tx_run(tx_run), .rx_valid(rx_valid),
    .rx_slot(rx_slot), .tx_req(tx_req), .tx_slot(tx_slot)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tsi_lane u_lane (
      .clk(clk), .rst_n(rst_n), .dn_s(dn_s[g]), .smp(smp),
      .byte_done(byte_done), .drv(drv), .load(load), .go_idle(go_idle),
      .run(tx_run), .tx_req(tx_req), .tx_byte(tx_byte[8*g +: 8]),
      .up(up[g]), .rx_byte(rx_byte[8*g +: 8])
    );
  end

endmodule

// File: tb/tb_tsi_serial_port.sv
module tb_tsi_serial_port;

  localparam int SLOTS = 4;
  localparam int SW    = 2;
  localparam int NBITS = SLOTS * 8;
  localparam int H     = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        mode = 3'd1;
  logic              dclk = 1'b0;
  logic              fsync = 1'b0;
  logic [1:0]        dn = 2'b00;
  logic [1:0]        up;
  logic              rx_valid, tx_req;
  logic [SW-1:0]     rx_slot, tx_slot;
  logic [15:0]       rx_byte, tx_byte;

  logic [7:0] pat_up [2][SLOTS];
  logic [7:0] pat_dn [2][SLOTS];
  logic [7:0] got    [2][SLOTS];
  int  checks = 0, fails = 0, rx_n = 0, tx_n = 0;
  bit  order_bad = 0, slot0_ff = 0, done = 0;

  always #4 clk = ~clk;

  assign tx_byte = {pat_up[1][tx_slot], pat_up[0][tx_slot]};

  tsi_serial_port #(.SLOTS(SLOTS), .LANES(2)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dclk(dclk), .fsync(fsync),
    .dn(dn), .up(up), .rx_valid(rx_valid), .rx_slot(rx_slot),
    .rx_byte(rx_byte), .tx_req(tx_req), .tx_slot(tx_slot), .tx_byte(tx_byte)
  );

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (int'(rx_slot) != rx_n % SLOTS) order_bad = 1;
      got[0][rx_slot] = rx_byte[7:0];
      got[1][rx_slot] = rx_byte[15:8];
      rx_n++;
    end
    if (rst_n && tx_req) tx_n++;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic dbit(int ln, int k);
    return pat_dn[ln][k/8][7-(k%8)];
  endfunction

  function automatic logic ubit(int ln, int k);
    logic [7:0] b;
    b = (k/8 == 0 && slot0_ff) ? 8'hFF : pat_up[ln][k/8];
    return b[7-(k%8)];
  endfunction

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  // One data clock period: rise with new data and sync, sample up before the fall.
  task automatic period(input logic [1:0] d, input logic fs, output logic [1:0] seen);
    dclk = 1'b1; dn = d; fsync = fs;
    half();
    seen = up;
    dclk = 1'b0;
    half();
  endtask

  task automatic run_frame(input bit dbl, input int nbits, input int fs_hold, input int chk_from);
    logic [1:0] u;
    rx_n = 0; order_bad = 0;
    if (dbl) begin
      period(2'b00, 1'b1, u);
      for (int k = 0; k < nbits; k++) begin
        period({dbit(1,k), dbit(0,k)}, 1'b0, u);
        if (k >= chk_from) chk("R6 double-rate up bit", {14'd0, u}, {14'd0, ubit(1,k), ubit(0,k)});
        period(2'b00, 1'b0, u);
      end
    end else begin
      for (int k = 0; k < nbits; k++) begin
        period({dbit(1,k), dbit(0,k)}, k < fs_hold, u);
        if (k >= 1 && k - 1 >= chk_from)
          chk("R6 single-rate up bit", {14'd0, u}, {14'd0, ubit(1,k-1), ubit(0,k-1)});
      end
    end
  endtask

  task automatic check_rx(input string req);
    chk({req, " rx count"}, 16'(rx_n), 16'(SLOTS));
    chk({req, " rx slot order"}, {15'd0, order_bad}, 16'd0);
    for (int s = 0; s < SLOTS; s++)
      chk({req, " rx byte"}, {got[1][s], got[0][s]}, {pat_dn[1][s], pat_dn[0][s]});
  endtask

  task automatic set_dn(input logic [7:0] seed);
    for (int s = 0; s < SLOTS; s++) begin
      pat_dn[0][s] = seed ^ 8'(s * 37);
      pat_dn[1][s] = ~seed + 8'(s * 11);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 up after reset", {14'd0, up}, 16'h0003);
    chk("R1 rx_valid after reset", {15'd0, rx_valid}, 16'd0);
    chk("R1 tx_req after reset", {15'd0, tx_req}, 16'd0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 up idle before first frame", {14'd0, up}, 16'h0003);
  endtask

  task automatic test_single_first();
    mode = 3'd1; set_dn(8'hA5); slot0_ff = 1; tx_n = 0;
    run_frame(0, NBITS, 1, 0);
    slot0_ff = 0;
    check_rx("R3 R5 single-rate");
    chk("R7 requests per frame", 16'(tx_n), 16'(SLOTS));
  endtask

  task automatic test_back_to_back();
    mode = 3'd4; set_dn(8'h3C);
    run_frame(0, NBITS, 1, 0);
    check_rx("R7 back-to-back frame");
  endtask

  task automatic test_late_sync();
    logic [1:0] u;
    rx_n = 0; tx_n = 0;
    period(2'b00, 1'b0, u);
    chk("R6 last single-rate up bit", {14'd0, u}, {14'd0, ubit(1,NBITS-1), ubit(0,NBITS-1)});
    for (int i = 0; i < 6; i++) begin
      period(2'b11, 1'b0, u);
      chk("R9 up high while idle", {14'd0, u}, 16'h0003);
    end
    chk("R9 no rx_valid while idle", 16'(rx_n), 16'd0);
    chk("R9 no tx_req while idle", 16'(tx_n), 16'd0);
    mode = 3'd3; set_dn(8'h96);
    run_frame(0, NBITS, 3, 0);
    check_rx("R4 R9 resumed frame, sync held high");
  endtask

  task automatic test_double();
    logic [1:0] u;
    for (int i = 0; i < 3; i++) period(2'b00, 1'b0, u);
    mode = 3'd0; set_dn(8'h5A);
    run_frame(1, NBITS, 1, 0);
    check_rx("R2 R5 double-rate");
    set_dn(8'hE1);
    run_frame(1, NBITS, 1, 0);
    check_rx("R2 second double-rate");
    period(2'b00, 1'b0, u);
    chk("R9 up high after double-rate frame", {14'd0, u}, 16'h0003);
  endtask

  task automatic test_early_sync();
    mode = 3'd2; set_dn(8'h0F);
    run_frame(0, 12, 1, 0);
    set_dn(8'hC3);
    run_frame(0, NBITS, 1, 8);
    check_rx("R8 restart after early sync");
  endtask

  initial begin
    for (int s = 0; s < SLOTS; s++) begin
      pat_up[0][s] = 8'h81 + 8'(s * 29);
      pat_up[1][s] = 8'h4E ^ 8'(s * 53);
    end
    test_reset();
    test_single_first();
    test_back_to_back();
    test_late_sync();
    test_double();
    test_early_sync();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule